// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the serial management master for the station-management link between a MAC and its PHY devices. Software writes one 32-bit command word into the frame register. If no frame is running and the clock-divider setting is non-zero, a transfer starts. The block first sends an optional run of 32 one-bits. It then sends the command word most significant bit first on the data line, timed by a management clock derived from the system clock.

The frame register does the shifting itself, so its contents are scrambled while a transfer is in flight. A frame whose opcode bits (word bits 29:28) equal `10` is a read. On a read, the block stops driving the data line partway through the turnaround pair and clocks in sixteen bits from the PHY. When it finishes, the register again holds the command word, with its low half replaced by the sampled PHY data. A write frame leaves the register exactly as written. Each completed frame sets a sticky event flag, which software can poll or route to an interrupt.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done_flag` are 0, `mdio_o` is 1 and `frame_q` is all zeros.
- R2: With `speed` = S > 0, `mdc` is a free-running square wave with a period of 4·S system clocks: high for 2·S and low for 2·S. With S = 0, `mdc` is held low.
- R3: A `frame_wr` pulse always loads `frame_wdata` into the frame register. It starts a frame only when the block is idle and `speed` is non-zero. With `speed` = 0 the block stays idle and `frame_q` shows the written word.
- R4: The line carries one bit per `mdc` period. Unless `no_preamble` is set at start, it first carries 32 ones. It then carries the 32 word bits, bit 31 first.
- R5: `mdio_o` and `mdio_oe` change only on the system clock edge at which `mdc` falls.
- R6: On a frame whose bits 29:28 are not `10`, `mdio_oe` is high for every bit time. After completion, `frame_q` equals the written word.
- R7: On a read frame (bits 29:28 = `10`), `mdio_oe` is low from frame bit index 15 (the second turnaround bit, counting from 0 at word bit 31) through index 31. `mdio_i` is sampled at each rising `mdc` edge of indices 16..31, and the samples fill `frame_q[15:0]` most significant bit first. `frame_q[31:16]` returns to its written value.
- R8: One full `mdc` period after the last bit begins, at the next falling `mdc` edge, `busy` and `mdio_oe` drop and `done_flag` sets. `done_flag` stays set until a `flag_clr` pulse clears it. If a set and a clear fall on the same clock, the set wins.
- R9: A `frame_wr` during a frame is not blocked. It does not restart the frame or change its length: `busy` falls on the same cycle as it would have without the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_wr | input | 1 | One-cycle write strobe for the frame register |
| frame_wdata | input | 32 | Command word to load |
| speed | input | SPD_W | Clock divider setting; 0 stops the management clock |
| no_preamble | input | 1 | Omit the 32-bit run of ones before the word |
| flag_clr | input | 1 | Clears the completion flag |
| mdio_i | input | 1 | Data line as seen at the pad |
| frame_q | output | 32 | Frame register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | A frame is in progress |
| done_flag | output | 1 | Sticky frame-completion flag |

## Verification
The assertions assume `speed` is held constant while a frame runs. Changing it mid-frame can stretch or freeze `mdc` without breaking any property, but the bit timing is then meaningless. They also assume the PHY holds `mdio_i` steady around each rising `mdc` edge, and they place no limit on `frame_wr` timing. The bench changes `speed` and `no_preamble` only while the block is idle. Its PHY model changes `mdio_i` only between system clock edges, just after the falling `mdc` edge. Exactly one run writes mid-frame, to exercise R9.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W   = 32;  // bits in one management word
  localparam int PRE_LEN   = 32;  // bits of all-ones lead-in
  localparam int DATA_W    = 16;  // data field width
  localparam int REL_IDX   = 15;  // frame bit index where master releases the line on reads
  localparam int CAP_IDX   = FRAME_W - DATA_W;  // first sampled frame bit index
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SPD_W-1:0] speed,
  output logic             mdc,
  output logic             fall_evt,
  output logic             rise_evt
);
  localparam int CW = SPD_W + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_lim;
  logic          mdc_q;
  logic          run;
  logic          tick;

  assign run      = (speed != '0);
  assign half_lim = CW'({speed, 1'b0}) - CW'(1);
  assign tick     = run && (cnt_q >= half_lim);
  assign fall_evt = tick && mdc_q;
  assign rise_evt = tick && !mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_MDC_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (speed == '0) |=> !mdc_q);  // R2
  AST_MDC_TOGGLE_RUNS: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc_q) |-> ($past(speed) != '0));  // R2
endmodule

// File: rtl/mdio_frame_reg.sv
module mdio_frame_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         rot_en,
  input  logic         cap_en,
  input  logic         cap_bit,
  output logic [W-1:0] q,
  output logic         msb
);
  logic [W-1:0] q_r;

  assign q   = q_r;
  assign msb = q_r[W-1];

  // Rotate left so that after W shifts the word is back in place; a sampled
  // bit dropped into bit 0 travels to its final data position by the end.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= wdata;
    end else if (rot_en) begin
      q_r <= {q_r[W-2:0], q_r[W-1]};
    end else if (cap_en) begin
      q_r[0] <= cap_bit;
    end
  end

  AST_ROT_CAP_APART: assert property (@(posedge clk) disable iff (rst)
    !(rot_en && cap_en));  // R7
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wr_is_read,
  input  logic wr_no_pre,
  input  logic fall_evt,
  input  logic rise_evt,
  input  logic frame_msb,
  output logic rot_en,
  output logic cap_en,
  output logic mdio_o,
  output logic mdio_oe,
  output logic busy,
  output logic fin
);
  localparam logic [CNT_W-1:0] PRE_K  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] REL_K  = CNT_W'(REL_IDX);
  localparam logic [CNT_W-1:0] CAP_K  = CNT_W'(CAP_IDX);

  seq_state_t       st_q;
  logic [CNT_W-1:0] k_q;
  logic             rd_q;
  logic             nopre_q;
  logic             o_q;
  logic             oe_q;

  logic [CNT_W-1:0] pre_len;
  logic [CNT_W-1:0] last_k;
  logic [CNT_W-1:0] nxt_k;
  logic [CNT_W-1:0] nxt_rel;
  logic [CNT_W-1:0] cur_rel;
  logic             last_bit;
  logic             advance;
  logic             nxt_is_frame;
  logic             cur_is_frame;
  logic             nxt_oe;

  assign pre_len      = nopre_q ? '0 : PRE_K;
  assign last_k       = pre_len + LAST_F;
  assign nxt_k        = (st_q == ST_LEAD) ? '0 : k_q + CNT_W'(1);
  assign nxt_rel      = nxt_k - pre_len;
  assign cur_rel      = k_q - pre_len;
  assign nxt_is_frame = (nxt_k >= pre_len);
  assign cur_is_frame = (k_q >= pre_len);
  assign last_bit     = (st_q == ST_SHIFT) && (k_q == last_k);
  assign advance      = fall_evt && ((st_q == ST_LEAD) || ((st_q == ST_SHIFT) && !last_bit));
  assign nxt_oe       = !(rd_q && nxt_is_frame && (nxt_rel >= REL_K));

  assign rot_en  = advance && nxt_is_frame;
  assign cap_en  = rise_evt && (st_q == ST_SHIFT) && rd_q && cur_is_frame && (cur_rel >= CAP_K);
  assign fin     = fall_evt && last_bit;
  assign busy    = (st_q != ST_IDLE);
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_LEAD;
            rd_q    <= wr_is_read;
            nopre_q <= wr_no_pre;
          end
        end
        default: begin
          if (fin) begin
            st_q <= ST_IDLE;
            k_q  <= '0;
            o_q  <= 1'b1;
            oe_q <= 1'b0;
          end else if (advance) begin
            st_q <= ST_SHIFT;
            k_q  <= nxt_k;
            o_q  <= nxt_is_frame ? frame_msb : 1'b1;
            oe_q <= nxt_oe;
          end
        end
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !oe_q);  // R8
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(o_q) |-> $past(fall_evt));  // R5
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> $past(fall_evt));  // R5
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SHIFT) && rd_q && cur_is_frame && (cur_rel >= REL_K)) |-> !oe_q);  // R7
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SHIFT) |-> (k_q <= last_k));  // R4
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_wr,
  input  logic [31:0]      frame_wdata,
  input  logic [SPD_W-1:0] speed,
  input  logic             no_preamble,
  input  logic             flag_clr,
  input  logic             mdio_i,
  output logic [31:0]      frame_q,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done_flag
);
  localparam int CNT_W = $clog2(PRE_LEN + FRAME_W + 1);

  logic fall_evt, rise_evt;
  logic rot_en, cap_en;
  logic frame_msb;
  logic fin;
  logic start;
  logic done_q;

  assign start     = frame_wr && !busy && (speed != '0);
  assign done_flag = done_q;

  mdio_mdc_gen #(.SPD_W(SPD_W)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .speed    (speed),
    .mdc      (mdc),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  mdio_frame_reg #(.W(FRAME_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_wr),
    .wdata   (frame_wdata),
    .rot_en  (rot_en),
    .cap_en  (cap_en),
    .cap_bit (mdio_i),
    .q       (frame_q),
    .msb     (frame_msb)
  );

  mdio_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .wr_is_read (frame_wdata[29:28] == OP_READ),
    .wr_no_pre  (no_preamble),
    .fall_evt   (fall_evt),
    .rise_evt   (rise_evt),
    .frame_msb  (frame_msb),
    .rot_en     (rot_en),
    .cap_en     (cap_en),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .busy       (busy),
    .fin        (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= (done_q && !flag_clr) || fin;
  end

  AST_NO_START_SPD0: assert property (@(posedge clk) disable iff (rst)
    (frame_wr && (speed == '0) && !busy) |=> !busy);  // R3
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy));  // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !flag_clr) |=> done_q);  // R8
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int SPD_W = 6;

  typedef struct packed { logic v; logic oe; logic cap; } ent_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_wr = 1'b0;
  logic [31:0]      frame_wdata = '0;
  logic [SPD_W-1:0] speed = '0;
  logic             no_preamble = 1'b0;
  logic             flag_clr = 1'b0;
  logic             mdio_i = 1'b1;
  logic [31:0]      frame_q;
  logic             mdc, mdio_o, mdio_oe, busy, done_flag;

  int nvec = 0;
  int nbad = 0;
  bit chk_on = 1'b0;
  bit chk_o  = 1'b1;
  bit ended  = 1'b0;

  // reference model state
  int          m_cnt;
  logic        m_mdc, m_o, m_oe, m_busy, m_done, m_cur_cap;
  logic [15:0] m_cap;
  int          m_dcnt;
  ent_t        mq[$];
  ent_t        m_e;
  logic        m_f, m_r;
  logic [15:0] phy_word = '0;

  always #2.5 clk = !clk;

  mdio_master #(.SPD_W(SPD_W)) u_mdio_master (
    .clk(clk), .rst(rst), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .speed(speed), .no_preamble(no_preamble), .flag_clr(flag_clr), .mdio_i(mdio_i),
    .frame_q(frame_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, evaluated at every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_mdc = 0; m_o = 1; m_oe = 0; m_busy = 0; m_done = 0;
      m_cur_cap = 0; m_cap = 0; m_dcnt = 0; mq.delete();
    end else begin
      m_f = 0; m_r = 0;
      if (speed == 0) begin m_cnt = 0; m_mdc = 0; end
      else if (m_cnt >= 2*int'(speed) - 1) begin
        m_cnt = 0; m_f = m_mdc; m_r = !m_mdc; m_mdc = !m_mdc;
      end else m_cnt = m_cnt + 1;
      if (m_r && m_busy && m_cur_cap) m_cap = {m_cap[14:0], mdio_i};
      if (flag_clr) m_done = 0;
      if (m_f && m_busy) begin
        if (mq.size() > 0) begin
          m_e = mq.pop_front();
          m_o = m_e.v; m_oe = m_e.oe; m_cur_cap = m_e.cap;
          if (m_e.cap) m_dcnt++;
        end else begin
          m_busy = 0; m_oe = 0; m_o = 1; m_cur_cap = 0; m_done = 1;
        end
      end else if (frame_wr && speed != 0 && !m_busy) begin
        if (!no_preamble) for (int i = 0; i < 32; i++) mq.push_back('{1'b1, 1'b1, 1'b0});
        for (int j = 0; j < 32; j++) begin
          bit rd;
          rd = (frame_wdata[29:28] == 2'b10);
          mq.push_back('{frame_wdata[31-j], !(rd && j >= 15), (rd && j >= 16)});
        end
        m_busy = 1; m_cap = 0; m_dcnt = 0;
      end
    end
  end

  // PHY model: presents the next data bit just after each falling management edge
  initial begin
    forever begin
      @(negedge clk);
      mdio_i = (m_cur_cap && m_dcnt > 0) ? phy_word[16 - m_dcnt] : 1'b1;
    end
  end

  // per-clock comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (chk_on && !ended) begin
        check(mdc == m_mdc, "R2 mdc", 32'(mdc), 32'(m_mdc));
        if (chk_o) check(mdio_o == m_o, "R4/R5 mdio_o", 32'(mdio_o), 32'(m_o));
        check(mdio_oe == m_oe, "R6/R7 mdio_oe", 32'(mdio_oe), 32'(m_oe));
        check(busy == m_busy, "R8/R9 busy", 32'(busy), 32'(m_busy));
        check(done_flag == m_done, "R8 done_flag", 32'(done_flag), 32'(m_done));
      end
    end
  end

  function automatic logic [31:0] mkw(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(done_flag == 1'b0, "R8 flag cleared", 32'(done_flag), 32'h0);
  endtask

  task automatic run_frame(input logic [31:0] w, input logic np, input logic [5:0] spd,
                           input logic [15:0] pd, input logic [31:0] expq, input string req);
    @(negedge clk); speed = spd; no_preamble = np; phy_word = pd;
    @(negedge clk); frame_wdata = w; frame_wr = 1'b1;
    @(negedge clk); frame_wr = 1'b0;
    check(busy == 1'b1, "R3 frame started", 32'(busy), 32'h1);
    wait_idle();
    check(frame_q == expq, req, frame_q, expq);
    check(done_flag == 1'b1, "R8 done set", 32'(done_flag), 32'h1);
    clear_flag();
  endtask

  initial begin
    int t_hi, t_lo;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(frame_q == 32'h0, "R1 frame_q", frame_q, 32'h0);
    check({mdc, mdio_oe, busy, done_flag, mdio_o} == 5'b00001, "R1 outputs",
          32'({mdc, mdio_oe, busy, done_flag, mdio_o}), 32'h1);
    chk_on = 1'b1;

    // R3: speed zero loads but does not start
    w = mkw(2'b01, 5'd3, 5'd4, 16'hBEEF);
    @(negedge clk); frame_wdata = w; frame_wr = 1'b1;
    @(negedge clk); frame_wr = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R3 no start at speed 0", 32'(busy), 32'h0);
    check(frame_q == w, "R3 register loaded", frame_q, w);
    check(mdc == 1'b0, "R2 mdc held low", 32'(mdc), 32'h0);

    // R2: period and duty at speed 3
    speed = 6'd3;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (mdc) break; end
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!mdc) break; end
    t_lo = 0; t_hi = 0;
    while (!mdc) begin t_lo++; @(negedge clk); end
    while (mdc)  begin t_hi++; @(negedge clk); end
    check(t_lo == 6, "R2 low time", 32'(t_lo), 32'd6);
    check(t_hi == 6, "R2 high time", 32'(t_hi), 32'd6);

    // R4 R6: write frame with preamble
    w = mkw(2'b01, 5'd1, 5'd2, 16'h5A3C);
    run_frame(w, 1'b0, 6'd2, 16'h0, w, "R6 write restores word");
    // R4 R6: write frame without preamble
    w = mkw(2'b01, 5'd31, 5'd0, 16'h8001);
    run_frame(w, 1'b1, 6'd1, 16'h0, w, "R6 write no preamble");
    // R7: read frames, data field content ignored
    w = mkw(2'b10, 5'd7, 5'd17, 16'hFFFF);
    run_frame(w, 1'b0, 6'd1, 16'hA5C3, {w[31:16], 16'hA5C3}, "R7 read capture");
    w = mkw(2'b10, 5'd0, 5'd31, 16'h0000);
    run_frame(w, 1'b1, 6'd3, 16'h1234, {w[31:16], 16'h1234}, "R7 read no preamble");

    // R9: write during a frame; line value is not compared for this run
    chk_o = 1'b0;
    w = mkw(2'b01, 5'd9, 5'd9, 16'h00FF);
    @(negedge clk); speed = 6'd1; no_preamble = 1'b0;
    @(negedge clk); frame_wdata = w; frame_wr = 1'b1;
    @(negedge clk); frame_wr = 1'b0;
    repeat (100) @(negedge clk);
    frame_wdata = mkw(2'b10, 5'd2, 5'd2, 16'h1111); frame_wr = 1'b1;
    @(negedge clk); frame_wr = 1'b0;
    check(busy == 1'b1, "R9 frame continues", 32'(busy), 32'h1);
    wait_idle();
    check(done_flag == 1'b1, "R9 done after same length", 32'(done_flag), 32'h1);
    chk_o = 1'b1;
    clear_flag();

    repeat (10) @(negedge clk);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nbad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule